// File: doc/BRIEF.md
# Call and Return Stack Unit

This block owns the program counter and a small return stack for a byte-coded controller. It handles four flow-control instructions. Two are two-byte transfers, a jump and a subroutine call, and each builds an 11-bit target from the top three bits of the opcode byte and the whole of the second byte. The other two are one-byte returns. One return restores only the program counter. The other restores the program counter and the upper status nibble. Every other opcode is left alone, so the rest of the core's decoder can handle it.

The stack is eight two-byte slots held in an internal byte RAM. The slots start at byte address 08h. A 3-bit pointer selects the slot, and the pointer wraps, so a ninth call with no return in between overwrites the oldest slot. Each instruction takes two clock cycles. In the first cycle the block writes the low byte of the return address. In the second cycle it writes the high byte, which holds the status nibble and address bits 11:8. The program counter and the pointer change at the end of the second cycle. While the core is not issuing a flow instruction, it can step the program counter by one.

Top module: `call_stack_unit`

## Requirements
- R1: After reset: pc_o is 0, sp_o is 0, busy_o is 0, status_we_o is 0 and status_o is 0.
- R2: An opcode whose bits 4:0 are 00100 is a jump. Two edges after acceptance, pc_o becomes {old pc_o[11], opcode[7:5], arg}. sp_o does not change and status_we_o stays 0.
- R3: An opcode whose bits 4:0 are 10100 is a call. It loads pc_o the same way as the jump, and sp_o increases by one.
- R4: A call stores in slot sp_o a return address equal to (pc_o at acceptance + 2) mod 4096, together with status_i as sampled at acceptance. The low byte of the slot, at address 8+2*slot, holds address bits 7:0. The high byte, at address 9+2*slot, holds {status[3:0], address[11:8]}.
- R5: Opcode 83h is a return. sp_o decreases by one, pc_o takes the address stored in the slot at the new sp_o, and status_we_o stays 0.
- R6: Opcode 93h is a return that also restores status. It behaves like 83h, and in addition status_o takes the stored status while status_we_o pulses high for exactly one cycle, in the same cycle the new pc_o appears.
- R7: busy_o is high for exactly the one cycle after acceptance. During that cycle pc_o and sp_o hold their old values, and op_valid_i and pc_adv_i are ignored.
- R8: sp_o wraps modulo 8. A call at sp_o = 7 moves sp_o to 0 and overwrites slot 7's predecessor order, so the ninth pending call replaces the oldest entry. A return at sp_o = 0 moves sp_o to 7.
- R9: Any other opcode leaves pc_o, sp_o, status_o and busy_o unchanged. If pc_adv_i is high in the same cycle, only the pc_adv_i step applies.
- R10: When the block is idle and accepts no flow instruction, pc_adv_i high increments pc_o by one modulo 4096. If a flow instruction is accepted in the same cycle, pc_adv_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Opcode and argument bytes present this cycle |
| op_byte_i | input | 8 | Opcode byte |
| op_arg_i | input | 8 | Second instruction byte (low target address) |
| pc_adv_i | input | 1 | Step the program counter by one when idle |
| status_i | input | 4 | Upper status nibble saved by a call |
| pc_o | output | 12 | Program counter |
| sp_o | output | 3 | Stack pointer |
| busy_o | output | 1 | Second cycle of a flow instruction |
| status_o | output | 4 | Status nibble restored by the status-restoring return |
| status_we_o | output | 1 | One-cycle strobe that status_o has been restored |

## Verification
The bench builds the block with its default parameters: a 3-bit pointer, a stack base of 8 and a 64-byte RAM. With eight slots, a handful of calls is enough to wrap the pointer in both directions, and a ring that is always full makes every random return meaningful. Because the program counter is 12 bits wide, a few directed jumps reach the edge cases: a return address that crosses into bit 11, a jump that must keep bit 11, and the step from FFFh back to 000h.

// File: rtl/csu_pkg.sv
package csu_pkg;

  localparam int PC_W = 12;
  localparam int ST_W = 4;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_JMP,
    CMD_CALL,
    CMD_RET,
    CMD_RETI
  } cmd_e;

  // Classify one opcode byte.
  function automatic cmd_e classify(input logic [7:0] op);
    if (op[4:0] == 5'b00100)      return CMD_JMP;
    else if (op[4:0] == 5'b10100) return CMD_CALL;
    else if (op == 8'h83)         return CMD_RET;
    else if (op == 8'h93)         return CMD_RETI;
    else                          return CMD_NONE;
  endfunction

  // Transfer target: page bit kept, opcode bits 7:5 above the argument byte.
  function automatic logic [PC_W-1:0] jump_target(input logic       page,
                                                  input logic [7:0] op,
                                                  input logic [7:0] arg);
    return {page, op[7:5], arg};
  endfunction

  // Address after a two-byte call.
  function automatic logic [PC_W-1:0] return_addr(input logic [PC_W-1:0] pc);
    return pc + PC_W'(2);
  endfunction

  // Upper byte of a slot: status nibble over the top address nibble.
  function automatic logic [7:0] pack_hi(input logic [ST_W-1:0] st,
                                         input logic [PC_W-1:0] pc);
    return {st, pc[PC_W-1:8]};
  endfunction

endpackage

// File: rtl/csu_decode.sv
module csu_decode
  import csu_pkg::*;
(
  input  logic       valid,
  input  logic       busy,
  input  logic [7:0] op,
  output cmd_e       cmd,
  output logic       accept
);
  always_comb begin
    cmd    = classify(op);
    accept = valid && !busy && (cmd != CMD_NONE);
  end
endmodule

// File: rtl/csu_stack_ram.sv
module csu_stack_ram #(
  parameter int WORDS = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_lo,
  input  logic [AW-1:0] raddr_hi,
  output logic [7:0]    rdata_lo,
  output logic [7:0]    rdata_hi
);
  logic [7:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_lo = mem[raddr_lo];
  assign rdata_hi = mem[raddr_hi];
endmodule

// File: rtl/csu_seq.sv
module csu_seq
  import csu_pkg::*;
#(
  parameter int SP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  cmd_e            cmd,
  input  logic [7:0]      op,
  input  logic [7:0]      arg,
  input  logic            pc_adv,
  input  logic [ST_W-1:0] status_in,
  input  logic [7:0]      pop_lo,
  input  logic [7:0]      pop_hi,
  output logic [PC_W-1:0] pc_q,
  output logic [SP_W-1:0] sp_q,
  output logic            busy_q,
  output cmd_e            cmd_q,
  output logic [PC_W-1:0] ret_q,
  output logic [ST_W-1:0] st_q,
  output logic [ST_W-1:0] status_q,
  output logic            status_we_q,
  output logic            ev_jmp,
  output logic            ev_call,
  output logic            ev_ret
);
  logic [PC_W-1:0] tgt_q;
  logic [PC_W-1:0] pop_pc;

  assign pop_pc  = {pop_hi[PC_W-9:0], pop_lo};
  assign ev_jmp  = busy_q && (cmd_q == CMD_JMP);
  assign ev_call = busy_q && (cmd_q == CMD_CALL);
  assign ev_ret  = busy_q && ((cmd_q == CMD_RET) || (cmd_q == CMD_RETI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q        <= '0;
      sp_q        <= '0;
      busy_q      <= 1'b0;
      cmd_q       <= CMD_NONE;
      tgt_q       <= '0;
      ret_q       <= '0;
      st_q        <= '0;
      status_q    <= '0;
      status_we_q <= 1'b0;
    end else begin
      status_we_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cmd_q  <= cmd;
        tgt_q  <= jump_target(pc_q[PC_W-1], op, arg);
        ret_q  <= return_addr(pc_q);
        st_q   <= status_in;
      end else if (busy_q) begin
        busy_q <= 1'b0;
        unique case (cmd_q)
          CMD_JMP:  pc_q <= tgt_q;
          CMD_CALL: begin
            pc_q <= tgt_q;
            sp_q <= sp_q + 1'b1;
          end
          CMD_RET: begin
            pc_q <= pop_pc;
            sp_q <= sp_q - 1'b1;
          end
          CMD_RETI: begin
            pc_q        <= pop_pc;
            sp_q        <= sp_q - 1'b1;
            status_q    <= pop_hi[7:8-ST_W];
            status_we_q <= 1'b1;
          end
          default: ;
        endcase
      end else if (pc_adv) begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/call_stack_unit.sv
module call_stack_unit
  import csu_pkg::*;
#(
  parameter int SP_W       = 3,
  parameter int STACK_BASE = 8,
  parameter int RAM_WORDS  = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid_i,
  input  logic [7:0]      op_byte_i,
  input  logic [7:0]      op_arg_i,
  input  logic            pc_adv_i,
  input  logic [ST_W-1:0] status_i,
  output logic [PC_W-1:0] pc_o,
  output logic [SP_W-1:0] sp_o,
  output logic            busy_o,
  output logic [ST_W-1:0] status_o,
  output logic            status_we_o
);
  localparam int AW = $clog2(RAM_WORDS);

  cmd_e            dec_cmd;
  cmd_e            cmd_q;
  logic            accept;
  logic [PC_W-1:0] ret_q;
  logic [ST_W-1:0] st_q;
  logic [7:0]      rd_lo, rd_hi;
  logic [SP_W-1:0] pop_slot;
  logic            ram_we;
  logic [AW-1:0]   ram_waddr;
  logic [7:0]      ram_wdata;
  logic            ev_jmp, ev_call, ev_ret;

  function automatic logic [AW-1:0] slot_addr(input logic [SP_W-1:0] slot,
                                              input logic            hi);
    return AW'(STACK_BASE) + AW'({slot, hi});
  endfunction

  csu_decode u_dec (
    .valid  (op_valid_i),
    .busy   (busy_o),
    .op     (op_byte_i),
    .cmd    (dec_cmd),
    .accept (accept)
  );

  csu_seq #(.SP_W(SP_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .cmd         (dec_cmd),
    .op          (op_byte_i),
    .arg         (op_arg_i),
    .pc_adv      (pc_adv_i),
    .status_in   (status_i),
    .pop_lo      (rd_lo),
    .pop_hi      (rd_hi),
    .pc_q        (pc_o),
    .sp_q        (sp_o),
    .busy_q      (busy_o),
    .cmd_q       (cmd_q),
    .ret_q       (ret_q),
    .st_q        (st_q),
    .status_q    (status_o),
    .status_we_q (status_we_o),
    .ev_jmp      (ev_jmp),
    .ev_call     (ev_call),
    .ev_ret      (ev_ret)
  );

  // Low byte goes in on the accepting edge, high byte on the finishing edge.
  always_comb begin
    pop_slot  = sp_o - 1'b1;
    ram_we    = (accept && dec_cmd == CMD_CALL) || ev_call;
    ram_waddr = slot_addr(sp_o, ev_call);
    ram_wdata = ev_call ? pack_hi(st_q, ret_q)
                        : return_addr(pc_o)[7:0];
  end

  csu_stack_ram #(.WORDS(RAM_WORDS)) u_ram (
    .clk      (clk),
    .we       (ram_we),
    .waddr    (ram_waddr),
    .wdata    (ram_wdata),
    .raddr_lo (slot_addr(pop_slot, 1'b0)),
    .raddr_hi (slot_addr(pop_slot, 1'b1)),
    .rdata_lo (rd_lo),
    .rdata_hi (rd_hi)
  );
endmodule

// File: rtl/csu_chk.sv
module csu_chk #(
  parameter int SP_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic [11:0]     pc,
  input logic [SP_W-1:0] sp,
  input logic            status_we,
  input logic            ev_jmp,
  input logic            ev_call,
  input logic            ev_ret
);
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R7

  AST_PC_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(pc)); // R7

  AST_SP_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(sp)); // R9

  AST_CALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_call |=> sp == $past(sp) + 1'b1); // R3

  AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ret |=> sp == $past(sp) - 1'b1); // R5

  AST_JMP_SP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jmp |=> $stable(sp)); // R2

  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_jmp || ev_call) |=> pc[11] == $past(pc[11])); // R2

  AST_STATUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    status_we |-> $past(ev_ret)); // R6

  AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    status_we |=> !status_we); // R6
endmodule

bind call_stack_unit csu_chk #(.SP_W(SP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_o),
  .pc        (pc_o),
  .sp        (sp_o),
  .status_we (status_we_o),
  .ev_jmp    (ev_jmp),
  .ev_call   (ev_call),
  .ev_ret    (ev_ret)
);

// File: tb/call_stack_unit_tb.sv
module call_stack_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = 8'h00;
  logic [7:0]  op_arg = 8'h00;
  logic        pc_adv = 1'b0;
  logic [3:0]  status = 4'h0;
  logic [11:0] pc;
  logic [2:0]  sp;
  logic        busy;
  logic [3:0]  st_out;
  logic        st_we;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [11:0] m_pc = '0;
  logic [2:0]  m_sp = '0;
  logic [3:0]  m_st = '0;
  logic [11:0] m_spc [8];
  logic [3:0]  m_sst [8];

  always #2.5 clk = ~clk;

  call_stack_unit u_dut (
    .clk (clk), .rst_n (rst_n), .op_valid_i (op_valid), .op_byte_i (op_byte),
    .op_arg_i (op_arg), .pc_adv_i (pc_adv), .status_i (status),
    .pc_o (pc), .sp_o (sp), .busy_o (busy), .status_o (st_out),
    .status_we_o (st_we)
  );

  // 0 other, 1 jump, 2 call, 3 return, 4 return with status
  function automatic int kind_of(input logic [7:0] op);
    if ((op & 8'h1F) == 8'h04) return 1;
    if ((op & 8'h1F) == 8'h14) return 2;
    if (op == 8'h83) return 3;
    if (op == 8'h93) return 4;
    return 0;
  endfunction

  function automatic logic [11:0] exp_target(input logic [11:0] p,
                                             input logic [7:0] op,
                                             input logic [7:0] arg);
    logic [11:0] t;
    t = p & 12'h800;
    t = t | (12'(op >> 5) << 8) | 12'(arg);
    return t;
  endfunction

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [7:0] op, input logic [7:0] arg,
                       input logic [3:0] st, input logic adv,
                       input logic poke, input string req);
    int k;
    logic [11:0] old_pc;
    k = kind_of(op);
    old_pc = m_pc;
    @(negedge clk);
    op_valid = 1'b1; op_byte = op; op_arg = arg; status = st; pc_adv = adv;
    @(negedge clk);
    if (k == 0) begin
      op_valid = 1'b0; pc_adv = 1'b0;
      if (adv) m_pc = m_pc + 12'd1;
      chk(req, "busy", int'(busy), 0);
      chk(req, "pc", int'(pc), int'(m_pc));
      chk(req, "sp", int'(sp), int'(m_sp));
      chk(req, "status", int'(st_out), int'(m_st));
      return;
    end
    chk("R7", "busy", int'(busy), 1);
    chk("R7", "pc held", int'(pc), int'(m_pc));
    if (poke) begin
      op_valid = 1'b1; op_byte = 8'h04; op_arg = 8'hFF; pc_adv = 1'b1;
    end else begin
      op_valid = 1'b0; pc_adv = 1'b0;
    end
    case (k)
      1: m_pc = exp_target(old_pc, op, arg);
      2: begin
        m_spc[m_sp] = old_pc + 12'd2;
        m_sst[m_sp] = st;
        m_sp = m_sp + 3'd1;
        m_pc = exp_target(old_pc, op, arg);
      end
      default: begin
        m_sp = m_sp - 3'd1;
        m_pc = m_spc[m_sp];
        if (k == 4) m_st = m_sst[m_sp];
      end
    endcase
    @(negedge clk);
    op_valid = 1'b0; pc_adv = 1'b0;
    chk(req, "pc", int'(pc), int'(m_pc));
    chk(req, "sp", int'(sp), int'(m_sp));
    chk("R7", "busy end", int'(busy), 0);
    chk(k == 4 ? "R6" : req, "status_we", int'(st_we), (k == 4) ? 1 : 0);
    chk(k == 4 ? "R6" : req, "status", int'(st_out), int'(m_st));
  endtask

  task automatic adv_only();
    @(negedge clk);
    pc_adv = 1'b1;
    @(negedge clk);
    pc_adv = 1'b0;
    m_pc = m_pc + 12'd1;
    chk("R10", "pc step", int'(pc), int'(m_pc));
    chk("R6", "strobe low", int'(st_we), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] op;
    int r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "pc", int'(pc), 0);
    chk("R1", "sp", int'(sp), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "status_we", int'(st_we), 0);
    chk("R1", "status", int'(st_out), 0);
    rst_n = 1'b1;

    // R10 stepping, R9 ignored opcodes
    adv_only();
    adv_only();
    do_op(8'h00, 8'h55, 4'h3, 1'b0, 1'b0, "R9");
    do_op(8'h83 ^ 8'h10 ^ 8'h80, 8'h00, 4'h0, 1'b1, 1'b0, "R9");

    // Fill all eight slots (R3, R4) then wrap (R8)
    for (int i = 0; i < 8; i++)
      do_op(8'h14 | 8'(i << 5), 8'(i * 16 + 3), 4'(i + 5), 1'b0, 1'b0, "R3");
    chk("R8", "sp wrapped", int'(sp), 0);
    do_op(8'h34, 8'h77, 4'hA, 1'b0, 1'b0, "R8");
    do_op(8'h93, 8'h00, 4'h0, 1'b0, 1'b0, "R8");
    do_op(8'h93, 8'h00, 4'h0, 1'b0, 1'b0, "R4");
    do_op(8'h83, 8'h00, 4'h0, 1'b0, 1'b0, "R5");

    // Busy-cycle poke ignored, adv with accepted op ignored (R7, R10)
    do_op(8'hA4, 8'h12, 4'h0, 1'b1, 1'b1, "R10");
    do_op(8'h14, 8'h40, 4'h9, 1'b1, 1'b1, "R7");

    // Page bit crossings: return address 0x800, jump keeps bit 11, wrap
    do_op(8'hE4, 8'hFE, 4'h0, 1'b0, 1'b0, "R2");
    do_op(8'h54, 8'h10, 4'hC, 1'b0, 1'b0, "R4");
    do_op(8'h93, 8'h00, 4'h0, 1'b0, 1'b0, "R6");
    chk("R4", "ret crosses page", int'(pc), 12'h800);
    do_op(8'hE4, 8'hFF, 4'h0, 1'b0, 1'b0, "R2");
    chk("R2", "page kept", int'(pc), 12'hFFF);
    adv_only();
    chk("R10", "wrap to zero", int'(pc), 0);
    do_op(8'hE4, 8'hFE, 4'h0, 1'b0, 1'b0, "R2");
    do_op(8'h00, 8'h00, 4'h0, 1'b1, 1'b0, "R10");
    do_op(8'hE4, 8'hFE, 4'h0, 1'b0, 1'b0, "R2");
    do_op(8'hF4, 8'hFE, 4'h0, 1'b1, 1'b0, "R3");
    do_op(8'h83, 8'h00, 4'h0, 1'b0, 1'b0, "R5");

    // Random traffic over a ring that is always full
    for (int n = 0; n < 400; n++) begin
      r = int'($urandom % 7);
      case (r)
        0: do_op(8'h04 | 8'($urandom << 5), 8'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom), "R2");
        1, 2: do_op(8'h14 | 8'($urandom << 5), 8'($urandom), 4'($urandom),
                    1'($urandom), 1'($urandom), "R3");
        3: do_op(8'h83, 8'($urandom), 4'($urandom), 1'($urandom),
                 1'($urandom), "R5");
        4: do_op(8'h93, 8'($urandom), 4'($urandom), 1'($urandom),
                 1'($urandom), "R6");
        5: begin
          op = 8'($urandom);
          while (kind_of(op) != 0) op = 8'($urandom);
          do_op(op, 8'($urandom), 4'($urandom), 1'($urandom), 1'b0, "R9");
        end
        default: adv_only();
      endcase
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule